// File: doc/BRIEF.md
# Indexed Register Window

This block is a 32-bit memory-mapped slave that exposes a larger register set through only two visible locations. A host first writes an index into a selector location, then reads or writes a data window that maps onto whichever internal register the index names. Behind the window sit an identity register, a read-only version word, an arbitration word that always reads zero, and a table of 64-bit routing entries. Each routing entry is reached as two 32-bit halves at consecutive index values.

The whole table is exported in parallel to a dispatch engine. That engine can set or clear each entry's acknowledge-pending flag (bit 14) through per-entry strobes. Whenever the host writes a valid table half, the block raises a one-cycle rescan request so that the engine re-evaluates the table. Accesses use a single-cycle strobe: a write takes effect at the clock edge, and read data is valid combinationally while the strobe is high.

Top module: `idxwin_regs`

## Requirements
- R1: After reset the selector and the 4-bit identity are zero, every table entry equals 0x0000_0000_0001_0000 (only the mask bit 16 set), and rescan is low.
- R2: Only address bits 7:0 are decoded. A write at offset 0x00 stores data bits 7:0 into the selector, and a read at offset 0x00 returns the selector in bits 7:0 with zeros above.
- R3: A window write (offset 0x10) while the selector is 0x00 stores data bits 27:24 as the identity and discards the other bits. The window then reads the identity in bits 27:24 with zeros elsewhere.
- R4: With the selector at 0x01 the window reads 0x11 in bits 7:0 and the entry count minus one in bits 23:16 (0x00170011 for 24 entries). Writes there change nothing.
- R5: With the selector at 0x02, or at any value outside 0x00..0x02 and 0x10..0x3F, the window reads zero. Writes there change no state and raise no rescan.
- R6: Entry n holds bits 31:0 at selector 0x10+2n and bits 63:32 at 0x11+2n. A window write replaces only the addressed half and leaves the other half unchanged.
- R7: Rescan is high for exactly the one cycle that follows a window write to a valid table index, and it is low in every other cycle.
- R8: rack_set[n] sets bit 14 of entry n at the same edge, rack_clr[n] clears it, and set wins when both are high. A host write to entry n's low half at that edge overrides both strobes, while a write to the high half does not.
- R9: A strobe at any offset other than 0x00 or 0x10 reads zero and writes nothing. bus_rdata is zero whenever no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte address; only bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read strobe is high |
| rack_set | input | NENT (24) | Per-entry set of acknowledge-pending bit |
| rack_clr | input | NENT (24) | Per-entry clear of acknowledge-pending bit |
| rescan | output | 1 | One-cycle request to re-evaluate the table |
| tbl_out | output | 64*NENT | All entries, entry n at bits 64n+63:64n |

## Verification
The hardest case to reach is a collision at one clock edge between a host window write and a dispatch strobe on the same entry. Reaching it needs the selector to be set up in an earlier cycle, followed by a window write issued with rack_set or rack_clr high in that same cycle. The bench does this for both the low half and the high half, and also drives set and clear together. Because the reference model runs alongside the design on every clock, it catches any wrong priority in the exported table in the very next cycle.

// File: rtl/idxwin_regs.sv
module idxwin_regs #(
  parameter int NENT = 24,
  parameter int AW = 12,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NENT-1:0]   rack_set,
  input  logic [NENT-1:0]   rack_clr,
  output logic              rescan,
  output logic [64*NENT-1:0] tbl_out
);
  localparam logic [7:0] BASE   = 8'h10;
  localparam logic [7:0] LAST   = 8'(16 + 2*NENT - 1);
  localparam logic [7:0] TOPPIN = 8'(NENT - 1);
  localparam int RIRR = 14;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] ent_q [NENT];

  wire [7:0] off    = bus_addr[7:0];
  wire       at_idx = bus_sel && off == 8'h00;
  wire       at_win = bus_sel && off == 8'h10;
  wire       in_tbl = sel_q >= BASE && sel_q <= LAST;
  wire [7:0] rel    = sel_q - BASE;
  wire [6:0] slot   = rel[7:1];
  wire       wr_tbl = at_win && bus_we && in_tbl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      rescan <= 1'b0;
    end else begin
      if (at_idx && bus_we) sel_q <= bus_wdata[7:0];
      if (at_win && bus_we && sel_q == 8'h00) id_q <= bus_wdata[27:24];
      rescan <= wr_tbl;
    end

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    wire hit = wr_tbl && slot == 7'(i);
    logic [63:0] nx;

    always_comb begin
      nx = ent_q[i];
      if (rack_set[i])      nx[RIRR] = 1'b1;
      else if (rack_clr[i]) nx[RIRR] = 1'b0;
      if (hit && !sel_q[0]) nx[31:0]  = bus_wdata;
      if (hit &&  sel_q[0]) nx[63:32] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ent_q[i] <= 64'h0000_0000_0001_0000;
      else        ent_q[i] <= nx;

    assign tbl_out[64*i +: 64] = ent_q[i];

    // R6
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel_q[0]) |=> (ent_q[i][31:15] == $past(ent_q[i][31:15]) &&
                             ent_q[i][13:0]  == $past(ent_q[i][13:0])));

    // R8
    rack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rack_set[i] && !(hit && !sel_q[0])) |=> ent_q[i][RIRR]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (off == 8'h00) bus_rdata = {24'h0, sel_q};
      else if (off == 8'h10) begin
        case (sel_q)
          8'h00: bus_rdata = {4'h0, id_q, 24'h0};
          8'h01: bus_rdata = {8'h00, TOPPIN, 8'h00, VERSION};
          8'h02: bus_rdata = '0;
          default:
            for (int k = 0; k < NENT; k++)
              if (in_tbl && slot == 7'(k))
                bus_rdata = sel_q[0] ? ent_q[k][63:32] : ent_q[k][31:0];
        endcase
      end
    end
  end

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && off == 8'h00) |=> $stable(sel_q));

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && off == 8'h10 && sel_q == 8'h00) |=> $stable(id_q));

  // R7
  rescan_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rescan |-> $past(bus_sel && bus_we && bus_addr[7:0] == 8'h10));

  // R9
  always_comb
    if (rst_n && !(bus_sel && !bus_we))
      idle_rd_chk: assert (bus_rdata == 32'h0);
endmodule

// File: tb/idxwin_regs_test.sv
`timescale 1ns/1ps
module idxwin_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [23:0] rack_set = 0, rack_clr = 0;
  logic rescan;
  logic [64*24-1:0] tbl_out;

  idxwin_regs uut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
                   .bus_rdata, .rack_set, .rack_clr, .rescan, .tbl_out);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [63:0] m_tbl [24];
  logic [7:0]  m_idx;
  logic [3:0]  m_id;
  logic        m_resc;

  function automatic logic [31:0] mread(logic s, logic w, logic [11:0] a);
    int e;
    if (!s || w) return 0;
    if (a[7:0] == 8'h00) return {24'h0, m_idx};
    if (a[7:0] != 8'h10) return 0;
    if (m_idx == 0) return {4'h0, m_id, 24'h0};
    if (m_idx == 1) return 32'h0017_0011;
    if (m_idx >= 16 && m_idx < 64) begin
      e = (int'(m_idx) - 16) / 2;
      return m_idx[0] ? m_tbl[e][63:32] : m_tbl[e][31:0];
    end
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic s, logic w, logic [11:0] a, logic [31:0] d,
                      logic [23:0] rs, logic [23:0] rc, string tag);
    int e;
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    rack_set = rs; rack_clr = rc;
    #1;
    chk(tag, "rdata", {32'h0, bus_rdata}, {32'h0, mread(s, w, a)});
    @(posedge clk);
    for (int i = 0; i < 24; i++)
      if (rs[i]) m_tbl[i][14] = 1'b1;
      else if (rc[i]) m_tbl[i][14] = 1'b0;
    m_resc = 0;
    if (s && w) begin
      if (a[7:0] == 8'h00) m_idx = d[7:0];
      else if (a[7:0] == 8'h10) begin
        if (m_idx == 0) m_id = d[27:24];
        else if (m_idx >= 16 && m_idx < 64) begin
          e = (int'(m_idx) - 16) / 2;
          if (m_idx[0]) m_tbl[e][63:32] = d; else m_tbl[e][31:0] = d;
          m_resc = 1;
        end
      end
    end
    #1;
    chk(tag, "rescan", {63'h0, rescan}, {63'h0, m_resc});
    begin
      logic ok = 1;
      for (int i = 0; i < 24; i++)
        if (tbl_out[64*i +: 64] !== m_tbl[i]) begin
          ok = 0;
          $display("FAIL %s entry %0d: actual=%h expected=%h", tag, i,
                   tbl_out[64*i +: 64], m_tbl[i]);
        end
      total++;
      if (!ok) bad++;
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(1, 1, a, d, 0, 0, tag);
  endtask
  task automatic rd(logic [11:0] a, string tag);
    step(1, 0, a, 0, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) m_tbl[i] = 64'h1_0000;
    m_idx = 0; m_id = 0; m_resc = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "rescan", {63'h0, rescan}, 0);
    for (int i = 0; i < 24; i++)
      chk("R1", "reset entry", tbl_out[64*i +: 64], 64'h0000_0000_0001_0000);
    @(negedge clk); rst_n = 1;
    rd(12'h000, "R1");
    rd(12'h010, "R1");

    // R2 selector, upper address bits ignored
    wr(12'h000, 32'hFFFF_FF05, "R2");
    rd(12'h000, "R2");
    wr(12'hA00, 32'h0000_0007, "R2");
    rd(12'h300, "R2");
    chk("R2", "sel value", {32'h0, bus_rdata}, 64'h7);

    // R3 identity
    wr(12'h000, 0, "R3");
    wr(12'h010, 32'hFFFF_FFFF, "R3");
    rd(12'h010, "R3");
    wr(12'hF10, 32'h05AB_CDEF, "R3");
    rd(12'h010, "R3");

    // R4 version
    wr(12'h000, 1, "R4");
    rd(12'h010, "R4");
    wr(12'h010, 32'hDEAD_BEEF, "R4");
    rd(12'h010, "R4");

    // R5 arbitration and unmapped indexes
    wr(12'h000, 2, "R5");
    rd(12'h010, "R5");
    wr(12'h010, 32'h1234_5678, "R5");
    foreach (m_tbl[i]) ;
    for (int v = 3; v < 256; v += 29) begin
      wr(12'h000, v, "R5");
      wr(12'h010, 32'hFFFF_FFFF, "R5");
      rd(12'h010, "R5");
    end
    wr(12'h000, 32'h40, "R5");
    wr(12'h010, 32'hFFFF_FFFF, "R5");
    rd(12'h010, "R5");
    wr(12'h000, 32'h0F, "R5");
    wr(12'h010, 32'hFFFF_FFFF, "R5");

    // R6/R7 table halves and rescan
    wr(12'h000, 32'h10, "R6");
    wr(12'h010, 32'hA5A5_A5A5, "R7");
    rd(12'h010, "R6");
    wr(12'h000, 32'h11, "R6");
    wr(12'h010, 32'h0F00_0001, "R7");
    rd(12'h010, "R6");
    wr(12'h000, 32'h3E, "R6");
    wr(12'h010, 32'h1111_2222, "R6");
    wr(12'h000, 32'h3F, "R6");
    wr(12'h010, 32'h3333_4444, "R6");
    rd(12'h010, "R6");
    for (int n = 1; n < 23; n += 5) begin
      wr(12'h000, 16 + 2*n + (n & 1), "R6");
      wr(12'h010, 32'hC0DE_0000 | n, "R6");
    end

    // R8 acknowledge strobes
    step(0, 0, 0, 0, 24'h000008, 0, "R8");
    step(0, 0, 0, 0, 0, 24'h000008, "R8");
    step(0, 0, 0, 0, 24'h800001, 24'h800001, "R8");
    step(0, 0, 0, 0, 0, 24'hFFFFFF, "R8");
    wr(12'h000, 32'h16, "R8");
    step(1, 1, 12'h010, 32'h0000_0000, 24'h000008, 0, "R8");
    step(0, 0, 0, 0, 24'h000008, 0, "R8");
    step(1, 1, 12'h010, 32'h0000_4000, 0, 24'h000008, "R8");
    wr(12'h000, 32'h17, "R8");
    step(1, 1, 12'h010, 32'h9999_9999, 0, 24'h000008, "R8");
    step(1, 1, 12'h010, 32'h7777_7777, 24'h000008, 0, "R8");
    rd(12'h010, "R8");

    // R9 other offsets
    wr(12'h000, 32'h10, "R9");
    wr(12'h004, 32'hFFFF_FFFF, "R9");
    wr(12'h011, 32'hFFFF_FFFF, "R9");
    wr(12'h014, 32'hFFFF_FFFF, "R9");
    rd(12'h004, "R9");
    rd(12'h014, "R9");
    rd(12'h0FF, "R9");
    step(0, 0, 12'h010, 0, 0, 0, "R9");
    rd(12'h000, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule